// File: doc/BRIEF.md
# MAC Receive Host Interface

This block sits between the receive path of a gigabit Ethernet MAC and a host receive buffer. The line side delivers one byte per strobe, marked with frame-start, frame-end and abort flags. Bytes arrive back to back at gigabit pacing. At 10/100 pacing there are idle gaps between them. Each accepted byte goes through one output register and is shown to the host on an 8-bit bus for exactly one 125 MHz clock cycle.

The host can only acknowledge. It cannot stall the stream. When a byte is on the bus and the host does not acknowledge it, the byte is lost and a receive overflow is flagged. The flag is both a one-cycle pulse and a sticky bit that the host clears. The start-of-packet marker stays up until the host acknowledges. End-of-packet is a single-cycle pulse on the last byte of every frame, including aborted frames. An abort forces end-of-packet onto the next byte presented, together with an abort flag, and the rest of that frame is discarded.

Top module: `mac_rx_host_if`

## Requirements
- R1: On the first byte of a frame (a line byte with `line_sof`=1), `host_sop` and `host_dvalid` rise in the same cycle, one clock after the line byte.
- R2: Once `host_sop` is high, it stays high through every following cycle until a cycle in which `host_ack`=1. It falls on the edge that ends that cycle.
- R3: A byte accepted on the line side appears on `host_data` one clock later, with bit n of the output equal to bit n of the input. `host_dvalid` is high for exactly that one cycle per byte.
- R4: If `host_dvalid`=1 and `host_ack`=0 in a cycle, `ovf_pulse` is high for the next cycle only. The byte is lost, and the next line byte is still presented on schedule.
- R5: `ovf_sticky` goes to 1 in the same cycle as `ovf_pulse` and stays at 1 until a cycle with `ovf_clear`=1 and no new overflow. In a cycle where an overflow and `ovf_clear` coincide, the set wins.
- R6: `host_eop` is high for one cycle, on the byte that was marked with `line_eof`, and only while `host_dvalid`=1.
- R7: An abort during a frame marks a byte with `host_eop`=1 and `host_abort`=1. If the abort comes with a byte, that byte is marked. If it comes alone, the next byte is marked. Later bytes of that frame are discarded until the next `line_sof`.
- R8: At 10/100 pacing (idle cycles between line bytes), `host_dvalid`, `host_eop` and `host_abort` stay low in the gap cycles, and no overflow is raised there.
- R9: Line bytes that arrive outside a frame (no frame open and no `line_sof`) never reach the host bus.
- R10: With `rst_n`=0 at a clock edge, all outputs are low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_valid | input | 1 | Line-side byte strobe |
| line_data | input | 8 | Line-side byte |
| line_sof | input | 1 | Byte is the first of a frame |
| line_eof | input | 1 | Byte is the last of a frame |
| line_abort | input | 1 | Current frame is aborted |
| host_ack | input | 1 | Host accepts the byte on the bus this cycle |
| ovf_clear | input | 1 | Clears the sticky overflow bit |
| host_sop | output | 1 | Start of packet, held until acknowledged |
| host_dvalid | output | 1 | Byte on `host_data` is valid |
| host_data | output | 8 | Receive byte to host |
| host_eop | output | 1 | Last byte of packet |
| host_abort | output | 1 | Packet ended by abort |
| ovf_pulse | output | 1 | One-cycle overflow indication |
| ovf_sticky | output | 1 | Sticky overflow status |

## Verification
The bench leaves the first byte of a frame unacknowledged. A design that drops start-of-packet after one cycle, or that stalls the stream instead of flagging the loss, then shows the wrong marker or a shifted byte sequence. It sends aborts alone inside 10/100 gaps and together with a byte. A design that misplaces the forced end-of-packet, or that passes on the tail of an aborted frame, puts extra or wrongly marked bytes on the bus. It also drives the overflow clear in the same cycle as a new overflow, and feeds bytes outside any frame, which catches a clear that wins over the set and stray bytes that leak out.

// File: rtl/mac_rx_pkg.sv
// Package: shared width and the beat record that passes from the frame
// tracker to the output stage. Assumes byte-wide line data.
package mac_rx_pkg;
    parameter int RX_BYTE_W = 8;

    typedef struct packed {
        logic [RX_BYTE_W-1:0] data;
        logic                 sop;
        logic                 eop;
        logic                 abrt;
    } rx_beat_t;
endpackage

// File: rtl/rx_frame_track.sv
// Frame tracker: decides which line bytes belong to an open frame and marks
// them with start, end and abort. An abort seen without a byte is kept
// pending and applied to the next byte. Assumes at most one byte per clock.
module rx_frame_track
    import mac_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_valid,
    input  logic [RX_BYTE_W-1:0] line_data,
    input  logic                 line_sof,
    input  logic                 line_eof,
    input  logic                 line_abort,
    output logic                 beat_load,
    output rx_beat_t             beat
);
    logic in_frame_q;
    logic abort_pend_q;
    logic start;

    // Classify the current line byte and build its markers.
    always_comb begin
        start      = line_valid && line_sof;
        beat_load  = line_valid && (in_frame_q || start);
        beat.data  = line_data;
        beat.sop   = start;
        beat.abrt  = line_abort || abort_pend_q;
        beat.eop   = line_eof || beat.abrt;
    end

    // Track frame membership and a pending abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q   <= 1'b0;
            abort_pend_q <= 1'b0;
        end else if (beat_load) begin
            abort_pend_q <= 1'b0;
            in_frame_q   <= !beat.eop;
        end else if (line_abort && in_frame_q) begin
            abort_pend_q <= 1'b1;
        end
    end

    // R7
    pend_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pend_q |-> in_frame_q);
endmodule

// File: rtl/rx_out_stage.sv
// Output stage: one register level that shows each accepted byte to the
// host for one cycle. Start-of-packet is held until the host acknowledges.
// The host cannot stall this stage.
module rx_out_stage
    import mac_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 beat_load,
    input  rx_beat_t             beat,
    input  logic                 host_ack,
    output logic                 host_sop,
    output logic                 host_dvalid,
    output logic [RX_BYTE_W-1:0] host_data,
    output logic                 host_eop,
    output logic                 host_abort
);
    // Register the byte and its single-cycle markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_dvalid <= 1'b0;
            host_data   <= '0;
            host_eop    <= 1'b0;
            host_abort  <= 1'b0;
        end else begin
            host_dvalid <= beat_load;
            host_eop    <= beat_load && beat.eop;
            host_abort  <= beat_load && beat.abrt;
            if (beat_load) host_data <= beat.data;
        end
    end

    // Hold start-of-packet until an acknowledge is sampled.
    always_ff @(posedge clk) begin
        if (!rst_n)                    host_sop <= 1'b0;
        else if (beat_load && beat.sop) host_sop <= 1'b1;
        else if (host_ack)             host_sop <= 1'b0;
    end

    // R2
    sop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sop && !host_ack) |=> host_sop);
    // R6
    eop_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_eop |-> host_dvalid);
    // R7
    abort_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_abort |-> host_eop);
endmodule

// File: rtl/rx_ovf_mon.sv
// Overflow monitor: flags any presented byte the host did not acknowledge,
// as a one-cycle pulse and as a sticky bit. A new overflow wins over a clear.
module rx_ovf_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic host_dvalid,
    input  logic host_ack,
    input  logic ovf_clear,
    output logic ovf_pulse,
    output logic ovf_sticky
);
    logic miss;

    // A missed byte is one shown without acknowledge.
    always_comb miss = host_dvalid && !host_ack;

    // Register the pulse and update the sticky bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_pulse  <= 1'b0;
            ovf_sticky <= 1'b0;
        end else begin
            ovf_pulse <= miss;
            if (miss)           ovf_sticky <= 1'b1;
            else if (ovf_clear) ovf_sticky <= 1'b0;
        end
    end

    // R5
    sticky_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> ovf_sticky);
    // R4
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> $past(host_dvalid));
endmodule

// File: rtl/mac_rx_host_if.sv
// Top: connects the frame tracker, the output stage and the overflow
// monitor. All logic runs on one 125 MHz clock with synchronous reset.
module mac_rx_host_if
    import mac_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_valid,
    input  logic [RX_BYTE_W-1:0] line_data,
    input  logic                 line_sof,
    input  logic                 line_eof,
    input  logic                 line_abort,
    input  logic                 host_ack,
    input  logic                 ovf_clear,
    output logic                 host_sop,
    output logic                 host_dvalid,
    output logic [RX_BYTE_W-1:0] host_data,
    output logic                 host_eop,
    output logic                 host_abort,
    output logic                 ovf_pulse,
    output logic                 ovf_sticky
);
    logic     beat_load;
    rx_beat_t beat;

    rx_frame_track u_track (
        .clk(clk), .rst_n(rst_n), .line_valid(line_valid),
        .line_data(line_data), .line_sof(line_sof), .line_eof(line_eof),
        .line_abort(line_abort), .beat_load(beat_load), .beat(beat)
    );

    rx_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .beat_load(beat_load), .beat(beat),
        .host_ack(host_ack), .host_sop(host_sop), .host_dvalid(host_dvalid),
        .host_data(host_data), .host_eop(host_eop), .host_abort(host_abort)
    );

    rx_ovf_mon u_ovf (
        .clk(clk), .rst_n(rst_n), .host_dvalid(host_dvalid),
        .host_ack(host_ack), .ovf_clear(ovf_clear),
        .ovf_pulse(ovf_pulse), .ovf_sticky(ovf_sticky)
    );

    // R1
    sop_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_sop) |-> host_dvalid);
endmodule

// File: tb/mac_rx_host_if_bench.sv
module mac_rx_host_if_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_valid = 1'b0, line_sof = 1'b0, line_eof = 1'b0, line_abort = 1'b0;
    logic [7:0] line_data = '0;
    logic       host_ack = 1'b0, ovf_clear = 1'b0;
    logic       host_sop, host_dvalid, host_eop, host_abort, ovf_pulse, ovf_sticky;
    logic [7:0] host_data;

    always #4 clk = ~clk;

    mac_rx_host_if u_mac_rx_host_if (
        .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_data(line_data),
        .line_sof(line_sof), .line_eof(line_eof), .line_abort(line_abort),
        .host_ack(host_ack), .ovf_clear(ovf_clear), .host_sop(host_sop),
        .host_dvalid(host_dvalid), .host_data(host_data), .host_eop(host_eop),
        .host_abort(host_abort), .ovf_pulse(ovf_pulse), .ovf_sticky(ovf_sticky)
    );

    typedef struct { logic [7:0] d; logic s; logic e; logic a; } exp_t;
    exp_t exp_q[$];

    int  n_chk = 0, n_bad = 0;
    bit  mon_on = 1'b0;
    bit  fin = 1'b0;
    // driver-side frame model (from R7, R9)
    bit  m_in_frame = 1'b0, m_pend = 1'b0;
    logic ack_next = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
        end
    endtask

    // One line-side cycle; k says whether the host acks this byte next cycle.
    task automatic beat(input bit v, input logic [7:0] d, input bit s, input bit e,
                        input bit a, input bit k, input bit clr);
        exp_t it;
        bit start, load;
        @(negedge clk);
        line_valid = v; line_data = d; line_sof = s; line_eof = e; line_abort = a;
        ovf_clear = clr;
        host_ack = ack_next;
        ack_next = k;
        start = v && s;
        load  = v && (m_in_frame || start);
        if (load) begin
            it.d = d; it.s = start; it.a = a || m_pend; it.e = e || it.a;
            exp_q.push_back(it);
            m_pend = 1'b0;
            m_in_frame = !it.e;
        end else if (a && m_in_frame) begin
            m_pend = 1'b1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) beat(0, 8'h00, 0, 0, 0, 1, 0);
    endtask

    // Monitor: compares outputs against the expected queue and the overflow model.
    bit  p_ovf = 1'b0, p_sticky = 1'b0, p_sop = 1'b0;
    always @(negedge clk) begin
        #1;
        if (mon_on) begin
            exp_t it;
            bit es;
            chk(ovf_pulse == p_ovf, "R4 ovf_pulse", ovf_pulse, p_ovf);
            chk(ovf_sticky == p_sticky, "R5 ovf_sticky", ovf_sticky, p_sticky);
            es = p_sop;
            if (host_dvalid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R9 unexpected byte", host_data, 0);
                end else begin
                    it = exp_q.pop_front();
                    es = it.s || p_sop;
                    chk(host_data == it.d, "R3 data", host_data, it.d);
                    chk(host_eop == it.e, "R6 eop", host_eop, it.e);
                    chk(host_abort == it.a, "R7 abort", host_abort, it.a);
                end
            end else begin
                chk(!host_eop && !host_abort, "R8 gap markers", {host_eop, host_abort}, 0);
            end
            chk(host_sop == es, "R1/R2 sop", host_sop, es);
            p_ovf    = host_dvalid && !host_ack;
            p_sticky = p_ovf ? 1'b1 : (ovf_clear ? 1'b0 : p_sticky);
            p_sop    = es && !host_ack;
        end
    end

    initial begin
        #1_000_000;
        if (!fin) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        chk({host_sop, host_dvalid, host_eop, host_abort, ovf_pulse, ovf_sticky} == 0,
            "R10 reset outputs", {host_sop, host_dvalid, host_eop, host_abort, ovf_pulse, ovf_sticky}, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle(2);

        // R1 R3 R6: gigabit frame, all acked, varied bit patterns
        beat(1, 8'hA5, 1, 0, 0, 1, 0);
        beat(1, 8'h01, 0, 0, 0, 1, 0);
        beat(1, 8'h80, 0, 0, 0, 1, 0);
        beat(1, 8'hFF, 0, 0, 0, 1, 0);
        beat(1, 8'h3C, 0, 1, 0, 1, 0);
        idle(3);

        // R2 R4 R5: first byte not acked, sop held, overflow, stream continues
        beat(1, 8'h11, 1, 0, 0, 0, 0);
        beat(1, 8'h22, 0, 0, 0, 0, 0);
        beat(1, 8'h33, 0, 1, 0, 1, 0);
        idle(3);
        // R5 clear with no overflow
        beat(0, 8'h00, 0, 0, 0, 1, 1);
        idle(2);

        // R8 R7: 10/100 pacing, lone abort in a gap marks the next byte
        beat(1, 8'h40, 1, 0, 0, 1, 0);
        idle(4);
        beat(1, 8'h41, 0, 0, 0, 1, 0);
        idle(2);
        beat(0, 8'h00, 0, 0, 1, 1, 0);
        idle(2);
        beat(1, 8'h42, 0, 0, 0, 1, 0);
        idle(2);
        // R7: remaining bytes of aborted frame dropped
        beat(1, 8'h43, 0, 0, 0, 1, 0);
        beat(1, 8'h44, 0, 1, 0, 1, 0);
        idle(2);

        // R9: bytes outside any frame
        beat(1, 8'h55, 0, 0, 0, 1, 0);
        beat(1, 8'h66, 0, 1, 0, 1, 0);
        idle(2);

        // R7: abort arriving with a byte
        beat(1, 8'h70, 1, 0, 0, 1, 0);
        beat(1, 8'h71, 0, 0, 1, 1, 0);
        beat(1, 8'h72, 0, 0, 0, 1, 0);
        idle(3);

        // R5: overflow and clear in the same cycle, set wins; then clear
        beat(1, 8'h90, 1, 1, 0, 0, 0);
        beat(0, 8'h00, 0, 0, 0, 1, 1);
        idle(3);
        beat(0, 8'h00, 0, 0, 0, 1, 1);
        idle(3);

        chk(exp_q.size() == 0, "R9 leftover expected bytes", exp_q.size(), 0);
        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule